// File: doc/BRIEF.md
# Block-Gated Host-to-Target Word Pipe

This endpoint moves a stream of 16-bit words from a host-side source into user logic. The host always leads the transfer, but user logic decides when a transfer may begin. It does so one whole block at a time. User logic raises a ready input to say it can absorb a complete block. The endpoint then marks the start of the block with a single-cycle strobe and delivers exactly `BLK_LEN` words, each qualified by a write strobe.

The host side is modelled as a generic source that presents an 8-bit endpoint address, a valid flag and a data word. The endpoint pops a word with `src_take` whenever it accepts one. Ready is looked at only when a new block is about to be admitted. Once a block has begun, only the source's valid flag can pause it, and it runs to its full length even if ready falls. Data reaches user logic two clocks after it is taken, through a small register pipe, so the block strobe always sits in its own cycle ahead of the first word. The host clock is nominally 48 MHz.

Top module: `blkthr_pipe_in`

## Requirements
- R1: After reset, `blk_stb`, `pipe_wr` and `src_take` are low while `usr_ready` is low.
- R2: Every word accepted with `src_take` high appears on `pipe_data` with `pipe_wr` high exactly two clocks later, in acceptance order; `pipe_wr` is never high without such a word.
- R3: `blk_stb` is high for one clock only, and the clock right after it carries the first word of the block on `pipe_wr`.
- R4: A block is admitted only if `usr_ready` is high in the clock the admission is decided, which is the clock before `blk_stb`. With `usr_ready` low and no block open, no strobe, no write and no take occur.
- R5: Each block carries exactly `BLK_LEN` write cycles, even when `usr_ready` falls after the block was admitted.
- R6: Inside a block, a clock where `src_valid` is low takes no word, and `pipe_wr` shows a gap two clocks later. The block resumes when `src_valid` returns.
- R7: `blk_stb` and `pipe_wr` are never high in the same clock.
- R8: A source whose address differs from the parameter `EP_ADDR` (default 8'h8A) is ignored: no take, no strobe, no write.
- R9: With `usr_ready` and `src_valid` held high at a matching address, the next `blk_stb` appears in the clock immediately after the last word of the previous block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_addr | input | 8 | Endpoint address offered by the source |
| src_valid | input | 1 | Source has a word available |
| src_data | input | 16 | Word offered by the source |
| src_take | output | 1 | Endpoint accepts the offered word this clock |
| usr_ready | input | 1 | User logic can absorb a full block |
| pipe_data | output | 16 | Word delivered to user logic |
| pipe_wr | output | 1 | `pipe_data` is valid this clock |
| blk_stb | output | 1 | One-clock marker ahead of each block |

## Verification
Two functions can land on neighbouring or shared clocks: the delivery of a block's last word and the strobe that opens the next block. Holding ready and valid high for several blocks provokes this. The bench then demands that the strobe follow the last word directly, never overlap it, and never overlap any other write. A second collision, a ready drop while a block is open, is provoked by a short ready pulse; it is judged by counting that exactly one block of full length comes out. The scoreboard compares every delivered word with the source order throughout, including phases where valid stutters and ready toggles.

// File: rtl/bpi_pkg.sv
package bpi_pkg;
  localparam int ADDR_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } bpi_state_e;

  // true when the word being accepted now closes the block
  function automatic logic is_last_word(input int taken, input int len);
    return (taken + 1) == len;
  endfunction

  function automatic logic addr_hit(input logic [ADDR_W-1:0] seen,
                                    input logic [ADDR_W-1:0] mine);
    return seen == mine;
  endfunction
endpackage

// File: rtl/bpi_admit_fsm.sv
module bpi_admit_fsm #(
  parameter int BLK_LEN = 8,
  parameter int CNT_W   = $clog2(BLK_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             usr_ready,
  output logic             take,
  output logic             start,
  output logic [CNT_W-1:0] cnt_q
);
  import bpi_pkg::*;

  bpi_state_e state_q;
  logic       run_take;
  logic       last;

  always_comb begin
    start    = (state_q == ST_IDLE) && req && usr_ready;
    run_take = (state_q == ST_RUN) && req;
    take     = start || run_take;
    last     = take && is_last_word(int'(cnt_q), BLK_LEN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      if (take) begin
        cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
      end
      if (last) begin
        state_q <= ST_GAP;
      end else if (start) begin
        state_q <= ST_RUN;
      end else if (state_q == ST_GAP) begin
        state_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/bpi_word_pipe.sv
module bpi_word_pipe #(
  parameter int DATA_W = 16,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);
  logic [STAGES-1:0] v_q;
  logic [DATA_W-1:0] d_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[i] <= 1'b0;
          d_q[i] <= '0;
        end else begin
          v_q[i] <= in_vld;
          if (in_vld) d_q[i] <= in_data;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[i] <= 1'b0;
          d_q[i] <= '0;
        end else begin
          v_q[i] <= v_q[i-1];
          if (v_q[i-1]) d_q[i] <= d_q[i-1];
        end
      end
    end
  end

  assign out_vld  = v_q[STAGES-1];
  assign out_data = d_q[STAGES-1];
endmodule

// File: rtl/blkthr_pipe_in.sv
module blkthr_pipe_in #(
  parameter int                           DATA_W  = 16,
  parameter int                           BLK_LEN = 8,
  parameter logic [bpi_pkg::ADDR_W-1:0]   EP_ADDR = 8'h8A
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [bpi_pkg::ADDR_W-1:0] src_addr,
  input  logic                       src_valid,
  input  logic [DATA_W-1:0]          src_data,
  output logic                       src_take,
  input  logic                       usr_ready,
  output logic [DATA_W-1:0]          pipe_data,
  output logic                       pipe_wr,
  output logic                       blk_stb
);
  import bpi_pkg::*;

  localparam int CNT_W = $clog2(BLK_LEN + 1);

  logic             req;
  logic             start_ev;
  logic [CNT_W-1:0] cnt_q;

  assign req = src_valid && addr_hit(src_addr, EP_ADDR);

  bpi_admit_fsm #(.BLK_LEN(BLK_LEN), .CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .usr_ready (usr_ready),
    .take      (src_take),
    .start     (start_ev),
    .cnt_q     (cnt_q)
  );

  // two stages so the strobe (one stage) leads the first word by a clock
  bpi_word_pipe #(.DATA_W(DATA_W), .STAGES(2)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (src_take),
    .in_data  (src_data),
    .out_vld  (pipe_wr),
    .out_data (pipe_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) blk_stb <= 1'b0;
    else        blk_stb <= start_ev;
  end
endmodule

// File: rtl/bpi_chk.sv
module bpi_chk #(
  parameter int DATA_W  = 16,
  parameter int BLK_LEN = 8,
  parameter int CNT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_valid,
  input logic [DATA_W-1:0] src_data,
  input logic              src_take,
  input logic              usr_ready,
  input logic [DATA_W-1:0] pipe_data,
  input logic              pipe_wr,
  input logic              blk_stb,
  input logic [CNT_W-1:0]  cnt_q
);
  a_r3_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    blk_stb |=> !blk_stb);

  a_r3_stb_leads_word: assert property (@(posedge clk) disable iff (!rst_n)
    blk_stb |=> pipe_wr);

  a_r7_stb_excl_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_stb && pipe_wr));

  a_r4_stb_had_ready: assert property (@(posedge clk) disable iff (!rst_n)
    blk_stb |-> $past(usr_ready));

  a_r2_wr_from_take: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_wr |-> $past(src_take, 2));

  a_r2_data_order: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_wr |-> (pipe_data == $past(src_data, 2)));

  a_r6_take_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    src_take |-> src_valid);

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < BLK_LEN);
endmodule

bind blkthr_pipe_in bpi_chk #(
  .DATA_W(DATA_W), .BLK_LEN(BLK_LEN), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_valid (src_valid),
  .src_data  (src_data),
  .src_take  (src_take),
  .usr_ready (usr_ready),
  .pipe_data (pipe_data),
  .pipe_wr   (pipe_wr),
  .blk_stb   (blk_stb),
  .cnt_q     (cnt_q)
);

// File: tb/blkthr_pipe_in_tb_top.sv
`timescale 1ns/1ps
module blkthr_pipe_in_tb_top;
  localparam int          DATA_W  = 16;
  localparam int          BLK_LEN = 8;
  localparam logic [7:0]  MY_ADDR = 8'h8A;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        src_addr = '0;
  logic              src_valid = 1'b0;
  logic [DATA_W-1:0] src_data = '0;
  logic              src_take;
  logic              usr_ready = 1'b0;
  logic [DATA_W-1:0] pipe_data;
  logic              pipe_wr;
  logic              blk_stb;

  always #5 clk = ~clk;

  blkthr_pipe_in #(.DATA_W(DATA_W), .BLK_LEN(BLK_LEN), .EP_ADDR(MY_ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_addr(src_addr), .src_valid(src_valid),
    .src_data(src_data), .src_take(src_take), .usr_ready(usr_ready),
    .pipe_data(pipe_data), .pipe_wr(pipe_wr), .blk_stb(blk_stb)
  );

  int errors = 0, checks = 0;
  logic [DATA_W-1:0] sb_q[$];
  logic [DATA_W-1:0] next_word = 16'hA500;
  int take_total = 0, wr_total = 0, stb_total = 0, stall_seen = 0;
  int idx = 0, inblk = BLK_LEN, last_end = -1, cont_since = 0;
  bit prev_stb = 0, mon_on = 0, cont_mode = 0, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // monitor: samples registered outputs at the falling edge
  always @(negedge clk) if (mon_on) begin
    idx++;
    if (pipe_wr) begin
      if (sb_q.size() == 0) chk(0, "R2 write without taken word", 1, 0);
      else begin
        logic [DATA_W-1:0] exp_w;
        exp_w = sb_q.pop_front();
        chk(pipe_data == exp_w, "R2 word order", int'(pipe_data), int'(exp_w));
      end
      chk(inblk < BLK_LEN, "R5 write outside block", inblk, BLK_LEN - 1);
      if (inblk == 0) chk(prev_stb, "R3 first word follows strobe", 0, 1);
      inblk++;
      if (inblk == BLK_LEN) last_end = idx;
      wr_total++;
    end else if (inblk > 0 && inblk < BLK_LEN) begin
      stall_seen++;
    end
    if (prev_stb) chk(pipe_wr, "R3 word after strobe", int'(pipe_wr), 1);
    if (blk_stb) begin
      chk(!pipe_wr, "R7 strobe with write", int'(pipe_wr), 0);
      chk(inblk == BLK_LEN, "R5 previous block length", inblk, BLK_LEN);
      chk(usr_ready, "R4 ready at admission", int'(usr_ready), 1);
      if (cont_mode && last_end > cont_since)
        chk(idx == last_end + 1, "R9 back-to-back strobe", idx - last_end, 1);
      inblk = 0;
      stb_total++;
    end
    prev_stb = blk_stb;
  end

  // driver: rmode 0 low, 1 high, 2 pulse, 3 toggling; vmode 0 off, 1 on, 2 stutter
  task automatic drive(input int n, input int rmode, input int vmode, input logic [7:0] a);
    for (int c = 0; c < n; c++) begin
      @(negedge clk); #2;
      case (rmode)
        0: usr_ready = 1'b0;
        1: usr_ready = 1'b1;
        2: usr_ready = (c < 3);
        default: usr_ready = ((c % 7) != 3);
      endcase
      case (vmode)
        0: src_valid = 1'b0;
        1: src_valid = 1'b1;
        default: src_valid = ((c % 3) != 2);
      endcase
      src_addr = a;
      src_data = next_word;
      #1;
      if (src_take) begin
        if (!src_valid) chk(0, "R6 take while invalid", 1, 0);
        sb_q.push_back(next_word);
        next_word++;
        take_total++;
      end
    end
  endtask

  initial begin
    int s0, w0, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk); #1;
    chk(!blk_stb, "R1 strobe after reset", int'(blk_stb), 0);
    chk(!pipe_wr, "R1 write after reset", int'(pipe_wr), 0);
    chk(!src_take, "R1 take after reset", int'(src_take), 0);

    s0 = stb_total; w0 = wr_total; t0 = take_total;
    drive(20, 0, 1, MY_ADDR);
    chk(stb_total == s0, "R4 no strobe while not ready", stb_total - s0, 0);
    chk(wr_total == w0, "R4 no write while not ready", wr_total - w0, 0);
    chk(take_total == t0, "R4 no take while not ready", take_total - t0, 0);

    s0 = stb_total; w0 = wr_total; t0 = take_total;
    drive(20, 1, 1, 8'h11);
    chk(take_total == t0, "R8 foreign address take", take_total - t0, 0);
    chk(stb_total == s0, "R8 foreign address strobe", stb_total - s0, 0);
    chk(wr_total == w0, "R8 foreign address write", wr_total - w0, 0);

    s0 = stb_total; w0 = wr_total;
    drive(20, 2, 1, MY_ADDR);
    chk(stb_total - s0 == 1, "R5 one block after ready pulse", stb_total - s0, 1);
    chk(wr_total - w0 == BLK_LEN, "R5 block completes after ready drop", wr_total - w0, BLK_LEN);

    cont_since = idx;
    cont_mode = 1;
    drive(40, 1, 1, MY_ADDR);
    cont_mode = 0;
    drive(15, 0, 1, MY_ADDR);

    drive(60, 3, 2, MY_ADDR);
    drive(15, 0, 1, MY_ADDR);
    drive(6, 0, 0, MY_ADDR);

    chk(sb_q.size() == 0, "R2 all taken words delivered", sb_q.size(), 0);
    chk(wr_total == take_total, "R2 writes equal takes", wr_total, take_total);
    chk(wr_total == stb_total * BLK_LEN, "R5 total block words", wr_total, stb_total * BLK_LEN);
    chk(stall_seen > 0, "R6 gap inside block seen", stall_seen, 1);
    chk(stb_total >= 8, "R9 several blocks streamed", stb_total, 8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule